// File: doc/BRIEF.md
# Four-Channel Compare Toggle Timer

This block is a free-running up-counter with four compare channels. The counter advances by one per clock while counting is enabled, and it wraps to zero after it reaches a programmable reload value. Each channel holds its own compare value. When the counter lands on that value, the channel sets its flag in a shared status register. If the channel is in toggle mode, it also inverts its output pin. Software uses this to produce square waves of independent frequencies. After each match it moves the compare value on by a step, and the addition wraps modulo 2^16.

The status register is set by hardware and cleared by writing zero. Software writes a mask that has zeros only at the flags it has serviced. That write keeps every other flag, and it keeps any event that arrives in the same clock cycle, so a single store never loses an interrupt. Set flags that are also enabled are ORed onto one compare interrupt line shared by all channels. Channel pins are driven only while the output enable is on.

Top module: `cmp_toggle_timer`

## Requirements
- R1: While the count-enable bit is 1, `count_o` increases by one on each clock. When it has reached the reload value, it goes to 0 on the next clock instead. While count-enable is 0, `count_o` holds its value. After reset the count is 0 and the reload value is 0xFFFF, which gives the full 16-bit range.
- R2: Status bit 0 (update flag) is set on the same clock edge at which the counter goes from the reload value to 0.
- R3: Status bit i+1 (i = 0..3) is set on the edge at which the counter moves, while counting, to a value equal to channel i's compare register. This happens whether or not the channel's interrupt enable is set. A compare value above the reload value never matches.
- R4: A write to the status register makes each bit (old AND written bit) OR event-this-cycle. Writing 0 clears a bit, and writing 1 has no effect. An event in the same cycle as a clearing write leaves its bit set.
- R5: Status bits 15..5 always read 0, whatever is written to them.
- R6: When mode bit i is 1, channel i's output state inverts on the same edge that sets its flag. When mode bit i is 0, the output state holds. Every output state is 0 after reset.
- R7: `ch_out_o[i]` equals channel i's output state while the output-enable bit is 1, and it is 0 otherwise. Clearing output enable does not change the held output state.
- R8: `irq_o` is the OR over bits 4..0 of (status AND interrupt-enable), with matching bit positions. It changes on the same edge as the status register.
- R9: Register writes (`wr_en`=1) take effect at the next clock edge. The addresses are:
  - 0: control. Bit 0 is count enable and bit 1 is output enable.
  - 1: reload value.
  - 2: interrupt enable, bits 4..0.
  - 3: toggle-mode bits, bits 3..0.
  - 4: status clear mask.
  - 8 to 11: the compare values of channels 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Write data |
| count_o | output | 16 | Current counter value |
| status_o | output | 16 | Status register (flags in bits 4..0) |
| irq_o | output | 1 | Combined compare/update interrupt |
| ch_out_o | output | 4 | Channel output pins |

## Verification
Every result is due one clock edge after the cycle that causes it. A write applied before an edge shows on the outputs after that edge. A compare flag, its toggle and the interrupt all appear on the edge at which the counter takes the matching value, with no extra pipeline stage. The bench drives inputs on the falling edge and updates a behavioural model on the rising edge. On each falling edge it compares count, status, interrupt and pins against that model, so every result is sampled half a period after the edge that produced it. Directed checks fix the cycle of interest by waiting for a known count. The clear-versus-event race, the full 16-bit wrap and the stopped counter are each checked at their exact edge.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int ADDR_W       = 4;
  localparam int ADR_CTRL     = 0;
  localparam int ADR_RELOAD   = 1;
  localparam int ADR_IRQ_EN   = 2;
  localparam int ADR_MODE     = 3;
  localparam int ADR_STATUS   = 4;
  localparam int ADR_CMP_BASE = 8;
  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_OE_BIT  = 1;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d,
  output logic         wrap
);
  assign wrap  = run && (cnt_q == reload);
  assign cnt_d = !run ? cnt_q : (wrap ? '0 : cnt_q + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_q != reload) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt_q)); // R1
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_q == reload) |=> (cnt_q == '0)); // R1
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] cnt_d,
  input  logic         wr_cmp,
  input  logic [W-1:0] wr_data,
  input  logic         toggle_en,
  output logic         match,
  output logic         tog_q
);
  logic [W-1:0] cmp_q;

  assign match = run && (cnt_d == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      tog_q <= 1'b0;
    end else begin
      if (wr_cmp) cmp_q <= wr_data;
      if (match && toggle_en) tog_q <= ~tog_q;
    end
  end

  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (rst)
    (match && toggle_en) |=> (tog_q != $past(tog_q))); // R6
  AST_TOG_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(match && toggle_en) |=> $stable(tog_q)); // R6
endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_clr,
  input  logic [N-1:0] wr_mask,
  input  logic [N-1:0] evt,
  output logic [N-1:0] flags_q,
  output logic [N-1:0] flags_d
);
  assign flags_d = (wr_clr ? (flags_q & wr_mask) : flags_q) | evt;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((flags_q & $past(evt)) == $past(evt))); // R4
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(evt)) == '0)); // R4
  AST_KEEP_UNWRITTEN: assert property (@(posedge clk) disable iff (rst)
    !wr_clr |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R4
endmodule

// File: rtl/cmp_toggle_timer.sv
module cmp_toggle_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [CNT_W-1:0]        wr_data,
  output logic [CNT_W-1:0]        count_o,
  output logic [CNT_W-1:0]        status_o,
  output logic                    irq_o,
  output logic [NUM_CH-1:0]       ch_out_o
);
  localparam int ST_W = NUM_CH + 1;

  logic              run_q, oe_q;
  logic [CNT_W-1:0]  reload_q;
  logic [ST_W-1:0]   ier_q, ier_d;
  logic [NUM_CH-1:0] mode_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wrap;
  logic [NUM_CH-1:0] match, tog_q;
  logic [ST_W-1:0]   evt, flags_q, flags_d;
  logic              irq_q;

  logic wr_ctrl, wr_rel, wr_ier, wr_mode, wr_stat;
  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
  assign wr_rel  = wr_en && (wr_addr == ADDR_W'(ADR_RELOAD));
  assign wr_ier  = wr_en && (wr_addr == ADDR_W'(ADR_IRQ_EN));
  assign wr_mode = wr_en && (wr_addr == ADDR_W'(ADR_MODE));
  assign wr_stat = wr_en && (wr_addr == ADDR_W'(ADR_STATUS));
  assign ier_d   = wr_ier ? wr_data[ST_W-1:0] : ier_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      oe_q     <= 1'b0;
      reload_q <= '1;
      ier_q    <= '0;
      mode_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_q <= wr_data[CTRL_RUN_BIT];
        oe_q  <= wr_data[CTRL_OE_BIT];
      end
      if (wr_rel)  reload_q <= wr_data;
      if (wr_mode) mode_q   <= wr_data[NUM_CH-1:0];
      ier_q <= ier_d;
      irq_q <= |(flags_d & ier_d);
    end
  end

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run_q), .reload(reload_q),
    .cnt_q(cnt_q), .cnt_d(cnt_d), .wrap(wrap)
  );

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    logic wr_cmp;
    assign wr_cmp = wr_en && (wr_addr == ADDR_W'(ADR_CMP_BASE + gi));
    tmr_channel #(.W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .run(run_q), .cnt_d(cnt_d),
      .wr_cmp(wr_cmp), .wr_data(wr_data), .toggle_en(mode_q[gi]),
      .match(match[gi]), .tog_q(tog_q[gi])
    );
  end

  assign evt = {match, wrap};

  tmr_status #(.N(ST_W)) u_st (
    .clk(clk), .rst(rst), .wr_clr(wr_stat), .wr_mask(wr_data[ST_W-1:0]),
    .evt(evt), .flags_q(flags_q), .flags_d(flags_d)
  );

  assign count_o  = cnt_q;
  assign status_o = {{(CNT_W-ST_W){1'b0}}, flags_q};
  assign irq_o    = irq_q;
  assign ch_out_o = tog_q & {NUM_CH{oe_q}};

  AST_UPD_FLAG: assert property (@(posedge clk) disable iff (rst)
    (run_q && cnt_q == reload_q) |=> flags_q[0]); // R2
  AST_IRQ_OR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == |(flags_q & ier_q))); // R8
  AST_PIN_GATED: assert property (@(posedge clk) disable iff (rst)
    !oe_q |-> (ch_out_o == '0)); // R7
endmodule

// File: tb/cmp_toggle_timer_tb_top.sv
`timescale 1ns/100ps
module cmp_toggle_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count_o, status_o;
  logic        irq_o;
  logic [3:0]  ch_out_o;

  int n_total = 0, n_fail = 0;
  bit live = 1'b0;

  always #2.5 clk = ~clk;

  cmp_toggle_timer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count_o(count_o), .status_o(status_o), .irq_o(irq_o), .ch_out_o(ch_out_o)
  );

  // behavioural reference model
  int unsigned m_cnt, m_rel, m_cmp [4];
  bit m_run, m_oe, m_irq;
  bit [4:0] m_st, m_ier;
  bit [3:0] m_mode, m_tog;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_rel = 16'hFFFF; m_run = 0; m_oe = 0; m_irq = 0;
      m_st = 0; m_ier = 0; m_mode = 0; m_tog = 0;
      for (int i = 0; i < 4; i++) m_cmp[i] = 0;
    end else begin
      int unsigned nxt;
      bit [4:0] ev, st;
      ev = 0; nxt = m_cnt;
      if (m_run) begin
        if (m_cnt == m_rel) begin nxt = 0; ev[0] = 1; end
        else nxt = (m_cnt + 1) % 65536;
        for (int i = 0; i < 4; i++)
          if (nxt == m_cmp[i]) begin
            ev[i+1] = 1;
            if (m_mode[i]) m_tog[i] = ~m_tog[i];
          end
      end
      st = m_st;
      if (wr_en && wr_addr == 4) st = st & wr_data[4:0];
      st = st | ev;
      if (wr_en) begin
        case (wr_addr)
          4'd0: begin m_run = wr_data[0]; m_oe = wr_data[1]; end
          4'd1: m_rel = wr_data;
          4'd2: m_ier = wr_data[4:0];
          4'd3: m_mode = wr_data[3:0];
          4'd8, 4'd9, 4'd10, 4'd11: m_cmp[wr_addr-8] = wr_data;
          default: ;
        endcase
      end
      m_cnt = nxt; m_st = st;
      m_irq = |(st & m_ier);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (live && !rst) begin
      chk("R1 count", count_o, m_cnt);
      chk("R2/R3/R4 status", status_o, {11'b0, m_st});
      chk("R8 irq", irq_o, m_irq);
      chk("R6/R7 pins", ch_out_o, m_oe ? m_tog : 4'b0);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    int guard = 0;
    while (count_o !== v && guard < 70000) begin @(negedge clk); guard++; end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  initial begin
    #(5.0 * 190000);
    n_total++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] held;
    repeat (4) @(negedge clk);
    rst = 1'b0; live = 1'b1;
    @(negedge clk);
    chk("R1 reset count", count_o, 0);
    chk("R4 reset status", status_o, 0);
    chk("R8 reset irq", irq_o, 0);
    chk("R6 reset pins", ch_out_o, 0);

    // R9 setup: reload 9, compares, modes, irq enable for channel 0
    wr(4'd1, 16'd9);
    wr(4'd8, 16'd3);
    wr(4'd9, 16'd7);
    wr(4'd10, 16'd0);
    wr(4'd11, 16'h0012);
    wr(4'd3, 16'h0007);
    wr(4'd2, 16'h0002);
    chk("R1 stopped", count_o, 0);
    wr(4'd0, 16'h0003);
    repeat (25) @(negedge clk);
    chk("R3 above-reload never matches", status_o[4], 1'b0);
    chk("R3 ch0 flag", status_o[1], 1'b1);
    chk("R2 update flag", status_o[0], 1'b1);

    // R4 race: clearing write in the cycle channel 0 matches
    wait_cnt(16'd2);
    wr(4'd4, 16'h0000);
    chk("R4 event wins over clear", status_o, 16'h0002);
    chk("R8 irq from ch0", irq_o, 1'b1);

    // R4/R5 writing ones has no effect, reserved read zero
    wait_cnt(16'd4);
    wr(4'd4, 16'hFFFF);
    chk("R4 ones no effect", status_o, 16'h0002);
    chk("R5 reserved zero", status_o & 16'hFFE0, 0);
    wr(4'd4, 16'hFFFD);
    chk("R4 single clear", status_o[1], 1'b0);
    chk("R8 irq drops", irq_o, 1'b0);

    // R7 output enable off keeps state hidden
    wr(4'd0, 16'h0001);
    repeat (12) @(negedge clk);
    chk("R7 pins gated", ch_out_o, 0);
    wr(4'd0, 16'h0003);
    repeat (12) @(negedge clk);

    // R1 counter hold
    wr(4'd0, 16'h0002);
    held = count_o;
    repeat (5) @(negedge clk);
    chk("R1 hold", count_o, held);

    // R6 mode off for channel 0 while running
    wr(4'd3, 16'h0000);
    wr(4'd0, 16'h0003);
    repeat (30) @(negedge clk);

    // R1/R2 full 16-bit range with default-style reload
    wr(4'd1, 16'hFFFF);
    wr(4'd8, 16'hFFFE);
    wr(4'd3, 16'h0001);
    wr(4'd2, 16'h0001);
    wait_cnt(16'd20);
    wr(4'd4, 16'h0000);
    wait_cnt(16'hFFFF);
    chk("R3 match near top", status_o[1], 1'b1);
    chk("R2 no update yet", status_o[0], 1'b0);
    @(negedge clk);
    chk("R1 full wrap", count_o, 0);
    chk("R2 update on wrap", status_o[0], 1'b1);
    chk("R8 irq on update", irq_o, 1'b1);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule